// File: doc/BRIEF.md
# External Bus Write Sequencer with Ready-Wait

This block runs one write access on an asynchronous external memory bus. A one-cycle start request captures the address, write data, byte enables and a set of timing counts. The block then walks the access through three phases for the write strobe: setup, pulse and hold. It drives an active-low chip select, an active-low write strobe, byte selects, the address and the data for the whole access. When the hold phase ends it raises a one-cycle completion pulse.

The write strobe controls the access. Its setup, pulse and hold counts set the length of the access. The chip select has its own start offset and its own width on the same timeline. It is normally set to fall no later than the write strobe and to rise no earlier.

A 2-bit wait-mode field selects how the active-low wait input is treated. In ready mode (2'b11), a two-flip-flop synchronizer feeds the wait input to the sequencer, which looks at it in one cycle only: the last cycle of the write pulse. If wait is asserted there, the access freezes with every strobe kept as it is. When the synchronized wait deasserts, the hold phase runs. In every other mode, and in every other cycle, the wait input has no effect.

Top module: `ebus_wr_seq`

## Requirements
- R1: After reset, and whenever no access is running, ncs_n_o and nwe_n_o are 1, data_oe_o is 0, be_n_o is all ones and done_o is 0.
- R2: start_i is accepted only when no access is running. A start_i that arrives during an access is ignored, and no second access follows from it.
- R3: nwe_n_o is 0 for exactly P cycles, where P is we_pulse_i, or 1 when we_pulse_i is 0. The low phase begins we_setup_i cycles after the first access cycle. Without a wait stall, data_oe_o stays high for we_setup_i + P + we_hold_i cycles.
- R4: ncs_n_o is 0 in the access cycles whose index t (counted from 0) satisfies cs_setup_i <= t < cs_setup_i + cs_pulse_i. It is never low outside the access.
- R5: Throughout the access, data_oe_o is 1 and addr_o, data_o and be_n_o hold the values captured at start. be_n_o is the bitwise inverse of the captured be_i.
- R6: done_o is high for exactly one cycle: the cycle right after the last access cycle.
- R7: When wait_mode_i captured at start is not 2'b11, nwait_n_i has no effect on any output timing.
- R8: In ready mode (2'b11), nwait_n_i reaches the sequencer two cycles after it changes. If it is asserted (0) in the last pulse cycle, the access stays in that cycle with all strobes unchanged until it deasserts. With nwait_n_i asserted from before start and released in access cycle r, the access gains max(0, r + 2 - L) cycles, where L = we_setup_i + P - 1.
- R9: In ready mode, a wait input that deasserts early enough to be clear by the last pulse cycle leaves the access length unchanged. So does one that asserts only after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle access request |
| addr_i | input | AW | Access address |
| data_i | input | DW | Write data |
| be_i | input | BEW | Byte enables, active high |
| we_setup_i | input | CW | Cycles before the write strobe falls |
| we_pulse_i | input | CW | Write strobe low cycles (0 is taken as 1) |
| we_hold_i | input | CW | Cycles after the write strobe rises |
| cs_setup_i | input | CW | Access cycle in which chip select falls |
| cs_pulse_i | input | CW | Chip select low cycles |
| wait_mode_i | input | 2 | Wait handling; 2'b11 is ready mode |
| nwait_n_i | input | 1 | External wait, active low, asynchronous |
| ncs_n_o | output | 1 | Chip select, active low |
| nwe_n_o | output | 1 | Write strobe, active low |
| addr_o | output | AW | Bus address |
| be_n_o | output | BEW | Byte selects, active low |
| data_o | output | DW | Bus write data |
| data_oe_o | output | 1 | Data driver enable, high during the access |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- The bus is quiet when idle.
- The captured address, data and byte selects stay stable while an access runs.
- The timeline moves forward by at most one step per cycle.
- Outside ready mode the timeline always advances.
- A stall freezes both strobes and happens only while the write strobe is low.
- Completion is a single pulse that coincides with the end of the access.

Only the bench scenarios can show the exact strobe widths and the two-cycle synchronizer delay. They also show the extra length caused by a wait that is released at a chosen cycle. Finally, they show that a wait released early or asserted late, a wait in a non-ready mode, and a start during an access all leave the access unchanged.

// File: rtl/ebus_wr_pkg.sv
package ebus_wr_pkg;

  typedef enum logic [1:0] {
    WM_NONE  = 2'b00,
    WM_RSV1  = 2'b01,
    WM_RSV2  = 2'b10,
    WM_READY = 2'b11
  } wait_mode_e;

  // A zero pulse count still yields one strobe cycle.
  function automatic int unsigned eff_pulse(input int unsigned p);
    return (p == 0) ? 1 : p;
  endfunction

  // Length of an access without stall, in cycles.
  function automatic int unsigned access_len(input int unsigned s,
                                             input int unsigned p,
                                             input int unsigned h);
    return s + eff_pulse(p) + h;
  endfunction

  // Index of the last write-pulse cycle on the access timeline.
  function automatic int unsigned last_pulse_idx(input int unsigned s,
                                                 input int unsigned p);
    return s + eff_pulse(p) - 1;
  endfunction

  // True when position t lies in [lo, lo+len).
  function automatic logic in_window(input int unsigned t,
                                     input int unsigned lo,
                                     input int unsigned len);
    return (t >= lo) && (t < lo + len);
  endfunction

endpackage

// File: rtl/ebus_wr_sync.sv
module ebus_wr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic async_n_i,
  output logic hit_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= async_n_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], async_n_i};
      end
    end
  endgenerate

  // Active-low input: asserted when the last stage reads 0.
  assign hit_o = ~sh_q[STAGES-1];
endmodule

// File: rtl/ebus_wr_timeline.sv
module ebus_wr_timeline #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [TW-1:0] len_i,
  input  logic [TW-1:0] last_pulse_i,
  input  logic          wait_en_i,
  input  logic          wait_hit_i,
  output logic          busy_o,
  output logic [TW-1:0] pos_o,
  output logic          at_last_pulse_o,
  output logic          stall_o,
  output logic          done_o
);
  logic at_final;

  assign at_last_pulse_o = busy_o && (pos_o == last_pulse_i);
  assign stall_o         = at_last_pulse_o && wait_en_i && wait_hit_i;
  assign at_final        = busy_o && (pos_o == len_i - TW'(1));

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      pos_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (go_i) begin
          busy_o <= 1'b1;
          pos_o  <= '0;
        end
      end else if (stall_o) begin
        pos_o <= pos_o;
      end else if (at_final) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else begin
        pos_o <= pos_o + TW'(1);
      end
    end
  end
endmodule

// File: rtl/ebus_wr_strobes.sv
module ebus_wr_strobes #(
  parameter int TW = 8
) (
  input  logic          busy_i,
  input  logic [TW-1:0] pos_i,
  input  logic [TW-1:0] we_lo_i,
  input  logic [TW-1:0] we_len_i,
  input  logic [TW-1:0] cs_lo_i,
  input  logic [TW-1:0] cs_len_i,
  output logic          ncs_n_o,
  output logic          nwe_n_o,
  output logic          oe_o
);
  import ebus_wr_pkg::*;

  logic we_on, cs_on;

  always_comb begin
    we_on = in_window(int'(pos_i), int'(we_lo_i), int'(we_len_i));
    cs_on = in_window(int'(pos_i), int'(cs_lo_i), int'(cs_len_i));
  end

  assign nwe_n_o = ~(busy_i && we_on);
  assign ncs_n_o = ~(busy_i && cs_on);
  assign oe_o    = busy_i;
endmodule

// File: rtl/ebus_wr_seq.sv
module ebus_wr_seq #(
  parameter int AW  = 24,
  parameter int DW  = 32,
  parameter int BEW = 4,
  parameter int CW  = 6
) (
  input  logic           clk_i,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  data_i,
  input  logic [BEW-1:0] be_i,
  input  logic [CW-1:0]  we_setup_i,
  input  logic [CW-1:0]  we_pulse_i,
  input  logic [CW-1:0]  we_hold_i,
  input  logic [CW-1:0]  cs_setup_i,
  input  logic [CW-1:0]  cs_pulse_i,
  input  logic [1:0]     wait_mode_i,
  input  logic           nwait_n_i,
  output logic           ncs_n_o,
  output logic           nwe_n_o,
  output logic [AW-1:0]  addr_o,
  output logic [BEW-1:0] be_n_o,
  output logic [DW-1:0]  data_o,
  output logic           data_oe_o,
  output logic           done_o
);
  import ebus_wr_pkg::*;

  localparam int TW = CW + 2;

  logic           busy, accept, stall, at_last_pulse, wait_hit;
  logic [TW-1:0]  pos;
  logic [AW-1:0]  q_addr;
  logic [DW-1:0]  q_data;
  logic [BEW-1:0] q_be;
  logic [CW-1:0]  q_ws, q_wp, q_wh, q_cs, q_cp;
  logic           q_ready;
  logic [TW-1:0]  len, last_idx, we_lo, we_len, cs_lo, cs_len;

  assign accept = start_i && !busy;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      q_addr  <= '0;
      q_data  <= '0;
      q_be    <= '0;
      q_ws    <= '0;
      q_wp    <= '0;
      q_wh    <= '0;
      q_cs    <= '0;
      q_cp    <= '0;
      q_ready <= 1'b0;
    end else if (accept) begin
      q_addr  <= addr_i;
      q_data  <= data_i;
      q_be    <= be_i;
      q_ws    <= we_setup_i;
      q_wp    <= we_pulse_i;
      q_wh    <= we_hold_i;
      q_cs    <= cs_setup_i;
      q_cp    <= cs_pulse_i;
      q_ready <= (wait_mode_e'(wait_mode_i) == WM_READY);
    end
  end

  always_comb begin
    len      = TW'(access_len(int'(q_ws), int'(q_wp), int'(q_wh)));
    last_idx = TW'(last_pulse_idx(int'(q_ws), int'(q_wp)));
    we_lo    = TW'(q_ws);
    we_len   = TW'(eff_pulse(int'(q_wp)));
    cs_lo    = TW'(q_cs);
    cs_len   = TW'(q_cp);
  end

  ebus_wr_sync #(.STAGES(2)) sync_i (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .async_n_i (nwait_n_i),
    .hit_o     (wait_hit)
  );

  ebus_wr_timeline #(.TW(TW)) tl_i (
    .clk_i           (clk_i),
    .rst_n           (rst_n),
    .go_i            (accept),
    .len_i           (len),
    .last_pulse_i    (last_idx),
    .wait_en_i       (q_ready),
    .wait_hit_i      (wait_hit),
    .busy_o          (busy),
    .pos_o           (pos),
    .at_last_pulse_o (at_last_pulse),
    .stall_o         (stall),
    .done_o          (done_o)
  );

  ebus_wr_strobes #(.TW(TW)) stb_i (
    .busy_i   (busy),
    .pos_i    (pos),
    .we_lo_i  (we_lo),
    .we_len_i (we_len),
    .cs_lo_i  (cs_lo),
    .cs_len_i (cs_len),
    .ncs_n_o  (ncs_n_o),
    .nwe_n_o  (nwe_n_o),
    .oe_o     (data_oe_o)
  );

  assign addr_o = q_addr;
  assign data_o = q_data;
  assign be_n_o = busy ? ~q_be : '1;
endmodule

// File: rtl/ebus_wr_seq_chk.sv
module ebus_wr_seq_chk #(
  parameter int AW  = 24,
  parameter int DW  = 32,
  parameter int BEW = 4,
  parameter int TW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic [TW-1:0]  pos,
  input logic           stall,
  input logic           ready,
  input logic           ncs_n,
  input logic           nwe_n,
  input logic           oe,
  input logic           done,
  input logic [AW-1:0]  addr,
  input logic [DW-1:0]  data,
  input logic [BEW-1:0] be_n
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ncs_n && nwe_n && !oe && (be_n == '1))); // R1

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((pos == $past(pos)) || (pos == $past(pos) + TW'(1)))); // R2

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr) && $stable(data) && $stable(be_n))); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R6

  AST_NONREADY_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !ready) |-> (pos != $past(pos))); // R7

  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stall) && busy) |-> ((pos == $past(pos)) && $stable(nwe_n) && $stable(ncs_n))); // R8

  AST_STALL_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !nwe_n); // R8
endmodule

bind ebus_wr_seq ebus_wr_seq_chk #(.AW(AW), .DW(DW), .BEW(BEW), .TW(TW)) chk_i (
  .clk   (clk_i),
  .rst_n (rst_n),
  .busy  (busy),
  .pos   (pos),
  .stall (stall),
  .ready (q_ready),
  .ncs_n (ncs_n_o),
  .nwe_n (nwe_n_o),
  .oe    (data_oe_o),
  .done  (done_o),
  .addr  (addr_o),
  .data  (data_o),
  .be_n  (be_n_o)
);

// File: tb/ebus_wr_seq_tb.sv
`timescale 1ns/1ps
module ebus_wr_seq_tb_top;
  localparam int AW = 24, DW = 32, BEW = 4, CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [BEW-1:0] be_i = '0;
  logic [CW-1:0] ws_i = '0, wp_i = '0, wh_i = '0, cs_i = '0, cp_i = '0;
  logic [1:0] mode_i = 2'b00;
  logic nwait_n = 1'b1;
  logic ncs_n, nwe_n, oe, done;
  logic [AW-1:0] addr_o;
  logic [BEW-1:0] be_n;
  logic [DW-1:0] data_o;

  always #2 clk = ~clk;

  ebus_wr_seq #(.AW(AW), .DW(DW), .BEW(BEW), .CW(CW)) dut_i (
    .clk_i(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr_i), .data_i(data_i),
    .be_i(be_i), .we_setup_i(ws_i), .we_pulse_i(wp_i), .we_hold_i(wh_i),
    .cs_setup_i(cs_i), .cs_pulse_i(cp_i), .wait_mode_i(mode_i), .nwait_n_i(nwait_n),
    .ncs_n_o(ncs_n), .nwe_n_o(nwe_n), .addr_o(addr_o), .be_n_o(be_n),
    .data_o(data_o), .data_oe_o(oe), .done_o(done)
  );

  typedef struct {
    int len; int nwe; int ncs;
    logic [AW-1:0] a; logic [DW-1:0] d; logic [BEW-1:0] bn;
    string tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  bit reported = 0;

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  // Monitor: pops one expected item per observed access.
  bit in_acc = 0;
  int c_len, c_nwe, c_ncs;
  bit bus_bad;
  exp_t cur;
  always @(negedge clk) begin
    if (rst_n) begin
      if (oe) begin
        if (!in_acc) begin
          in_acc = 1; c_len = 0; c_nwe = 0; c_ncs = 0; bus_bad = 0;
          if (sb.size() == 0) begin
            check(0, "R2 unexpected access started", 1, 0);
            cur.len = 0; cur.nwe = 0; cur.ncs = 0; cur.a = addr_o; cur.d = data_o;
            cur.bn = be_n; cur.tag = "spurious";
          end else cur = sb.pop_front();
        end
        c_len++;
        if (!nwe_n) c_nwe++;
        if (!ncs_n) c_ncs++;
        if (addr_o !== cur.a || data_o !== cur.d || be_n !== cur.bn || done) bus_bad = 1;
      end else if (in_acc) begin
        in_acc = 0;
        check(done === 1'b1, {"R6 done after access ", cur.tag}, int'(done), 1);
        check(c_len == cur.len, {"R3/R8 access length ", cur.tag}, c_len, cur.len);
        check(c_nwe == cur.nwe, {"R3 nwe low cycles ", cur.tag}, c_nwe, cur.nwe);
        check(c_ncs == cur.ncs, {"R4 ncs low cycles ", cur.tag}, c_ncs, cur.ncs);
        check(!bus_bad, {"R5 bus held during access ", cur.tag}, int'(bus_bad), 0);
      end
    end
  end

  // kind: 0 none, 1 wait low before start released at cycle wv,
  //       2 wait asserted at cycle wv, 3 extra start at cycle wv
  task automatic run(input int ws, input int wp, input int wh, input int cs, input int cp,
                     input logic [1:0] mode, input int kind, input int wv,
                     input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [BEW-1:0] be, input string tag);
    exp_t e;
    int wpe, tot, last, extra, cend, ncs_exp;
    wpe = (wp == 0) ? 1 : wp;
    tot = ws + wpe + wh;
    last = ws + wpe - 1;
    extra = 0;
    if (mode == 2'b11 && kind == 1 && wv + 2 > last) extra = wv + 2 - last;
    cend = (cs + cp < tot) ? cs + cp : tot;
    ncs_exp = (cs < tot) ? cend - cs : 0;
    if (extra > 0 && cs <= last && last < cs + cp) ncs_exp += extra;
    e.len = tot + extra; e.nwe = wpe + extra; e.ncs = ncs_exp;
    e.a = a; e.d = d; e.bn = ~be; e.tag = tag;
    if (kind == 1) begin
      nwait_n = 1'b0;
      repeat (3) @(negedge clk);
    end
    sb.push_back(e);
    addr_i = a; data_i = d; be_i = be;
    ws_i = CW'(ws); wp_i = CW'(wp); wh_i = CW'(wh); cs_i = CW'(cs); cp_i = CW'(cp);
    mode_i = mode; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < tot + extra + 3; c++) begin
      if (kind == 1 && c == wv) nwait_n = 1'b1;
      if (kind == 2 && c == wv) nwait_n = 1'b0;
      if (kind == 3 && c == wv) begin start = 1'b1; addr_i = ~a; data_i = ~d; end
      if (kind == 3 && c == wv + 1) start = 1'b0;
      @(negedge clk);
    end
    nwait_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ncs_n === 1'b1, "R1 ncs_n idle", int'(ncs_n), 1);
    check(nwe_n === 1'b1, "R1 nwe_n idle", int'(nwe_n), 1);
    check(oe === 1'b0, "R1 data_oe idle", int'(oe), 0);
    check(done === 1'b0, "R1 done idle", int'(done), 0);
    check(be_n === '1, "R1 be_n idle", int'(be_n), 15);

    run(2, 5, 2, 1, 7, 2'b00, 0, 0, 24'h12_3456, 32'hDEAD_BEEF, 4'b0011, "basic");       // R3 R4 R5
    run(0, 0, 0, 0, 1, 2'b00, 0, 0, 24'h00_0001, 32'h0000_0001, 4'b1111, "minimal");     // R3 zero pulse
    run(2, 5, 2, 1, 7, 2'b11, 1, 7, 24'h00_0AA0, 32'h1111_2222, 4'b1000, "ready_wait");  // R8 extra 3
    run(2, 5, 2, 1, 7, 2'b11, 1, 4, 24'h00_0AA1, 32'h3333_4444, 4'b0100, "early_rel");   // R9 boundary
    run(2, 5, 2, 1, 7, 2'b11, 1, 5, 24'h00_0AA2, 32'h5555_6666, 4'b0010, "one_stall");   // R8 extra 1
    run(2, 5, 2, 1, 7, 2'b11, 2, 6, 24'h00_0AA3, 32'h7777_8888, 4'b0001, "late_assert"); // R9
    run(2, 5, 2, 1, 7, 2'b01, 1, 10, 24'h00_0BB0, 32'h9999_AAAA, 4'b1100, "mode01");     // R7
    run(3, 2, 1, 0, 7, 2'b10, 1, 9, 24'h00_0BB1, 32'hBBBB_CCCC, 4'b0110, "mode10");      // R7
    run(2, 5, 2, 1, 7, 2'b00, 3, 2, 24'h00_0CC0, 32'hCAFE_F00D, 4'b1010, "start_busy");  // R2
    check(oe === 1'b0 && sb.size() == 0, "R2 no access from ignored start", int'(oe), 0);
    run(0, 1, 3, 0, 1, 2'b11, 1, 4, 24'h00_0DD0, 32'h0BAD_F00D, 4'b0101, "zero_setup");  // R8 extra 6
    run(1, 2, 3, 1, 63, 2'b00, 0, 0, 24'h00_0EE0, 32'h1234_5678, 4'b1111, "cs_clip");    // R4 clip
    run(3, 2, 2, 0, 2, 2'b00, 0, 0, 24'h00_0EE1, 32'h8765_4321, 4'b1001, "cs_early");    // R4
    run(63, 63, 63, 60, 63, 2'b11, 1, 130, 24'hFF_FFFF, 32'hFFFF_0000, 4'b1110, "long"); // R8 extra 7
    check(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);
    report();
    $finish;
  end
endmodule